// File: doc/BRIEF.md
# Three-Pin Port with External-Bus Strobe Override

This block is a small general-purpose I/O port of three pins. It sits behind an 8-bit register interface with two registers: an output data latch and a direction register. Each pin is an input when its direction bit is 1 and an output when that bit is 0. A read of the data register returns the levels present on the pins, after a two-flop synchronizer, and not the latch contents. The latch can be written while a pin is still an input. This lets software load a known level before turning the pin into an output.

A two-bit configuration mode input can take the pins away from software. In the two bus modes, all three pins are driven from an external-bus controller's strobes: address latch enable, an active-low output enable and an active-low write. Register writes are still accepted in those modes, but they only reach the pins once the port returns to one of the two general-purpose modes.

Top module: `busport_gpio`

## Requirements
- R1: Bits 7:3 of every register read are zero, whatever value was written there.
- R2: With mode_i[1]=0, pin_oe_o[i] is 1 (driving) exactly when direction bit i is 0. A direction bit of 1 makes that pin an input.
- R3: With mode_i[1]=0, pin_o equals the data latch. It changes in the cycle after the rising edge that wrote the latch.
- R4: A read with reg_addr_i=0 returns on bits 2:0 the pin_i value that was sampled two rising edges earlier. It never returns the latch.
- R5: A write with reg_addr_i=0 loads reg_wdata_i[2:0] into the latch, even while the pins are inputs. A pin that later turns into an output drives that value.
- R6: A read with reg_addr_i=1 returns the direction register on bits 2:0.
- R7: With mode_i[1]=1 (modes 2 and 3), pin_oe_o is 3'b111 and pin_o is {wr_ni, oe_ni, ale_i}, with address latch enable on bit 0, output enable on bit 1 and write on bit 2.
- R8: After reset the direction register reads 3'b111, the latch is 3'b000 and the synchronizer holds zero.
- R9: Writes made in bus mode do not change pin_o or pin_oe_o while that mode lasts. They take effect when mode_i[1] returns to 0.
- R10: Registers change only on a rising edge with reg_wr_i=1. When reg_rd_i=0, reg_rdata_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Configuration mode; bit 1 set selects bus mode |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects the data register, 1 the direction register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data |
| pin_i | input | 3 | Levels seen on the pins |
| pin_o | output | 3 | Levels driven onto the pins |
| pin_oe_o | output | 3 | Per-pin drive enable |
| ale_i | input | 1 | Address latch enable from the bus controller |
| oe_ni | input | 1 | Output enable strobe from the bus controller, active low |
| wr_ni | input | 1 | Write strobe from the bus controller, active low |

## Verification
A wrong direction bit appears on pin_oe_o in the cycle after the write. A wrong latch bit appears on pin_o as soon as that pin is an output in a general-purpose mode. A fault in the synchronizer depth or source shifts the data-register read by a cycle, or makes it return the latch instead of the pins, and the per-clock model comparison catches this on the next read. A leak from the registers into bus mode shows at once on pin_o or pin_oe_o while the strobes are being toggled.

// File: rtl/busport_pkg.sv
package busport_pkg;
  localparam int unsigned PORT_W = 3;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SYNC_N = 2;

  typedef enum logic {
    ADDR_DATA = 1'b0,
    ADDR_DIR  = 1'b1
  } reg_sel_e;

  function automatic logic is_bus_mode(input logic [1:0] mode);
    return mode[1];
  endfunction
endpackage

// File: rtl/busport_sync.sv
module busport_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/busport_regs.sv
module busport_regs
  import busport_pkg::*;
#(
  parameter int unsigned PW = PORT_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  reg_sel_e      sel_i,
  input  logic [PW-1:0] wdata_i,
  input  logic [PW-1:0] pins_sync_i,
  output logic [DW-1:0] rdata_o,
  output logic [PW-1:0] dir_o,
  output logic [PW-1:0] lat_o
);
  logic [PW-1:0] dir_q, lat_q;
  logic [PW-1:0] rd_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
      lat_q <= '0;
    end else if (wr_i) begin
      if (sel_i == ADDR_DIR) dir_q <= wdata_i;
      else                   lat_q <= wdata_i;
    end
  end

  // data register reads the pins, not the latch
  always_comb begin
    rd_sel = (sel_i == ADDR_DIR) ? dir_q : pins_sync_i;
    rdata_o = '0;
    if (rd_i) rdata_o[PW-1:0] = rd_sel;
  end

  assign dir_o = dir_q;
  assign lat_o = lat_q;
endmodule

// File: rtl/busport_pinmux.sv
module busport_pinmux #(
  parameter int unsigned PW = 3
) (
  input  logic          bus_en_i,
  input  logic [PW-1:0] dir_i,
  input  logic [PW-1:0] lat_i,
  input  logic          ale_i,
  input  logic          oe_ni,
  input  logic          wr_ni,
  output logic [PW-1:0] pin_o,
  output logic [PW-1:0] pin_oe_o
);
  logic [PW-1:0] strobes;

  always_comb begin
    strobes    = '0;
    strobes[0] = ale_i;
    strobes[1] = oe_ni;
    strobes[2] = wr_ni;
  end

  assign pin_o    = bus_en_i ? strobes : lat_i;
  assign pin_oe_o = bus_en_i ? '1 : ~dir_i;
endmodule

// File: rtl/busport_gpio.sv
module busport_gpio
  import busport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] pin_o,
  output logic [PORT_W-1:0] pin_oe_o,
  input  logic              ale_i,
  input  logic              oe_ni,
  input  logic              wr_ni
);
  logic [PORT_W-1:0] pins_sync, dir, lat;
  logic              unused_in;
  reg_sel_e          sel;

  assign unused_in = ^{reg_wdata_i[DATA_W-1:PORT_W], mode_i[0]};
  assign sel       = reg_sel_e'(reg_addr_i);

  busport_sync #(.W(PORT_W), .STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pins_sync)
  );

  busport_regs #(.PW(PORT_W), .DW(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (reg_rd_i),
    .wr_i        (reg_wr_i),
    .sel_i       (sel),
    .wdata_i     (reg_wdata_i[PORT_W-1:0]),
    .pins_sync_i (pins_sync),
    .rdata_o     (reg_rdata_o),
    .dir_o       (dir),
    .lat_o       (lat)
  );

  busport_pinmux #(.PW(PORT_W)) u_mux (
    .bus_en_i (is_bus_mode(mode_i)),
    .dir_i    (dir),
    .lat_i    (lat),
    .ale_i    (ale_i),
    .oe_ni    (oe_ni),
    .wr_ni    (wr_ni),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
  );
endmodule

// File: rtl/busport_gpio_chk.sv
module busport_gpio_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       reg_rd_i,
  input logic       reg_wr_i,
  input logic       reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic [2:0] pin_i,
  input logic [2:0] pin_o,
  input logic [2:0] pin_oe_o,
  input logic       ale_i,
  input logic       oe_ni,
  input logic       wr_ni
);
  logic [1:0] warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  assert_upper_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[7:3] == 5'd0);

  assert_dir_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i && !mode_i[1]) |=>
      (mode_i[1] || pin_oe_o == ~$past(reg_wdata_i[2:0])));

  assert_pin_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2'd2 && reg_rd_i && !reg_addr_i) |-> reg_rdata_o[2:0] == $past(pin_i, 2));

  assert_latch_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !reg_addr_i) |=> (mode_i[1] || pin_o == $past(reg_wdata_i[2:0])));

  assert_bus_override_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |-> (pin_oe_o == 3'b111 && pin_o == {wr_ni, oe_ni, ale_i}));

  assert_bus_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i[1]) && mode_i[1] && $stable({ale_i, oe_ni, wr_ni})) |-> $stable(pin_o));

  assert_idle_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |-> reg_rdata_o == 8'd0);
endmodule

bind busport_gpio busport_gpio_chk u_chk (.*);

// File: tb/tb_busport_gpio.sv
`timescale 1ns/1ps
module tb_busport_gpio;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       rd = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [2:0] pin_in = 3'd0, pin_out, pin_oe;
  logic       ale = 1'b0, oe_n = 1'b1, wr_n = 1'b1;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  busport_gpio dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pin_i(pin_in),
    .pin_o(pin_out), .pin_oe_o(pin_oe), .ale_i(ale), .oe_ni(oe_n), .wr_ni(wr_n)
  );

  // behavioural reference
  int m_dir, m_lat;
  int sq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 7; m_lat = 0; sq = '{0, 0};
    end else begin
      sq.push_back(int'(pin_in));
      void'(sq.pop_front());
      if (wr) begin
        if (addr) m_dir = int'(wdata) % 8;
        else      m_lat = int'(wdata) % 8;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int e_rd, e_oe, e_po;
    e_rd = !rd ? 0 : (addr ? m_dir : sq[0]);
    if (mode[1]) begin
      e_oe = 7; e_po = {wr_n, oe_n, ale};
    end else begin
      e_oe = (~m_dir) & 7; e_po = m_lat;
    end
    check(addr ? "R6 rdata" : "R4 rdata", int'(rdata), e_rd);
    check(mode[1] ? "R7 pin_oe" : "R2 pin_oe", int'(pin_oe), e_oe);
    check(mode[1] ? "R7 pin_o" : "R3 pin_o", int'(pin_out), e_po);
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    rd = 0; wr = 0;
  endtask

  task automatic reg_write(bit a, int v);
    cyc(); wr = 1; rd = 0; addr = a; wdata = 8'(v);
    cyc(); idle();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8: reset state
    cyc(); rd = 1; addr = 1;
    cyc(); check("R8 dir reset", int'(rdata), 7);
    check("R8 latch reset", int'(pin_out), 0);
    check("R8 oe reset", int'(pin_oe), 0);
    addr = 0;
    cyc(); check("R8 sync reset", int'(rdata), 0);
    idle();

    // R5: load latch before direction, then turn bit 2 to output
    reg_write(0, 0);
    reg_write(0, 8'h04);
    check("R5 latch hidden while input", int'(pin_oe), 0);
    reg_write(1, 8'h03);
    cyc(); check("R5 preloaded drive", int'(pin_out & pin_oe), 4);
    check("R2 oe bit2 only", int'(pin_oe), 4);

    // R1: upper bits written ones read back zero
    reg_write(1, 8'hFA);
    rd = 1; addr = 1;
    cyc(); check("R1 dir upper zero", int'(rdata), 2);
    pin_in = 3'b101; addr = 0;
    cyc(); cyc(); cyc(); check("R4 pins not latch", int'(rdata), 5);

    // R10: write strobe low has no effect, read strobe low gives zero
    idle(); addr = 1; wdata = 8'h00;
    cyc(); check("R10 idle rdata", int'(rdata), 0);
    cyc(); check("R10 no write", int'(pin_oe), 5);

    // random traffic in GPIO mode
    for (int i = 0; i < 400; i++) begin
      cyc();
      rd = 1'($urandom); wr = 1'($urandom); addr = 1'($urandom);
      wdata = 8'($urandom); pin_in = 3'($urandom); mode = 2'($urandom % 2);
    end
    idle();

    // R7/R9: bus mode with writes accepted but hidden
    reg_write(1, 8'h07);
    reg_write(0, 8'h00);
    cyc(); mode = 2'd2;
    reg_write(1, 8'h00);
    reg_write(0, 8'h06);
    check("R9 oe held in bus", int'(pin_oe), 7);
    for (int i = 0; i < 200; i++) begin
      cyc();
      ale = 1'($urandom); oe_n = 1'($urandom); wr_n = 1'($urandom);
      mode = 2'd2 + 2'($urandom % 2);
      wr = 1'($urandom); addr = 1'($urandom); wdata = 8'($urandom);
      rd = 1'($urandom);
    end
    idle();
    reg_write(1, 8'h00);
    reg_write(0, 8'h06);
    ale = 1; oe_n = 0; wr_n = 1;
    cyc(); check("R7 strobe map", int'(pin_out), 3'b101);
    mode = 2'd1;
    cyc(); check("R9 writes visible after", int'(pin_out), 6);
    check("R9 dir visible after", int'(pin_oe), 7);

    repeat (4) cyc();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule